// File: doc/BRIEF.md
# Interrupt Pending/Service Control Unit

This block keeps the interrupt state of a peripheral that has five interrupt sources: two data ports and three counter/timers. Every source has four flags: pending, under-service, enable and error. Software changes the first three only by writing a 3-bit command into the upper bits of that source's command/status byte. Reading the same byte returns the four flags. Hardware events from the source set pending and latch a 3-bit condition code. A second event that arrives while pending is still set raises the error flag.

One shared request line rises when the master enable is on and some source is enabled and pending with no service in progress at its own or a higher priority. An acknowledge pulse marks the highest-priority requesting source as under service. It also captures that source's vector into a current-vector register. The vector comes from one of three stored vectors: port A, port B, or the timer group. If the master byte selects status insertion for that group, vector bits 3:1 are replaced by the source's condition code.

A daisy-chain enable output is pulled low while any source is under service or while software disables the lower chain. A reset bit in the master byte clears every flag and holds the flags cleared until software writes the bit back to zero.

Top module: `icu_ctrl`

## Requirements
- R1: After `rst_n` is released, the master byte (address 0) reads 0x01, every source status byte reads 0x00, `irq` is 0, `chain_out` is 1 and `vec_drive` is 0.
- R2: Writing the master byte with bit 0 set stores 0x01 and clears pending, enable, under-service, error and condition code of every source in that same write cycle. While bit 0 stays set, events and commands have no effect. A master write with bit 0 clear stores the written byte.
- R3: A write to a source byte decodes bits 7:5 as: 0 no action, 1 clear pending and under-service, 2 set under-service, 3 clear under-service, 4 set pending, 5 clear pending, 6 set enable, 7 clear enable. A read of the byte returns under-service at bit 7, enable at bit 6, pending at bit 5, error at bit 4, and zeros below. The source bytes sit at addresses 8 (timer 3), 9 (port A), 10 (timer 2), 11 (port B) and 12 (timer 1).
- R4: A source event sets pending and latches its 3-bit condition code. An event that arrives while pending is already set also sets error. Error clears only through command 1 or command 5.
- R5: `irq` is 1 exactly when master bit 7 is set and some source is enabled and pending while no source of equal or higher priority is under service. Priority runs from address 8 (highest) to address 12 (lowest).
- R6: An `ack` pulse while `irq` is 1 sets under-service on the highest-priority requesting source. An `ack` while `irq` is 0 changes nothing.
- R7: Stored vectors live at address 1 (port A), 2 (port B) and 3 (timers). On a granted `ack`, the current vector (address 4 and `vec_out`) takes the winner's group vector. If the group's insertion bit is set (master bit 4 port A, bit 3 port B, bit 2 timers), vector bits 3:1 carry the winner's condition code instead.
- R8: `vec_drive` is 1 for the one cycle after a granted `ack`, unless master bit 5 (no vector) was set at the `ack`. At all other times it is 0.
- R9: `chain_out` is 0 whenever any source is under service or master bit 6 is set. Otherwise it is 1.
- R10: When an event and a pending-clearing command hit the same source in one cycle, pending ends up set. When a granted `ack` and an under-service clear hit the same source in one cycle, under-service ends up set.
- R11: Writes to address 4 have no effect. Addresses 5 to 7 and 13 to 15 read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| evt | input | 5 | Per-source event pulses, bit i = source at address 8+i |
| evt_cond | input | 15 | Per-source 3-bit condition code, source i at bits 3i+2:3i |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Shared interrupt request |
| chain_out | output | 1 | Daisy-chain enable toward lower-priority devices |
| vec_out | output | 8 | Current vector |
| vec_drive | output | 1 | Vector valid, one cycle after a granted acknowledge |

## Verification
The bench builds the unit with its default five sources. At that size, every combination of the 32 pending patterns and the 32 under-service patterns is driven in turn, so the priority blocking rule and the winner's vector can be checked for each of the 1024 cases. On every source, each of the eight commands is applied from each of the eight pending/enable/service starting states. Directed cases then cover the error overrun, the reset-bit hold, vector suppression, vectors without status insertion, chain blocking and the same-cycle collisions.

// File: rtl/icu_pkg.sv
package icu_pkg;

  localparam int NSRC_DEF = 5;
  localparam int CODE_W   = 3;
  localparam int ADDR_W   = 4;

  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_MCTL  = 4'd0;
  localparam addr_t A_VEC_A = 4'd1;
  localparam addr_t A_VEC_B = 4'd2;
  localparam addr_t A_VEC_T = 4'd3;
  localparam addr_t A_CUR   = 4'd4;
  localparam addr_t A_SRC0  = 4'd8;

  // master control bit positions
  localparam int MB_MIE   = 7;
  localparam int MB_DLC   = 6;
  localparam int MB_NV    = 5;
  localparam int MB_VIS_A = 4;
  localparam int MB_VIS_B = 3;
  localparam int MB_VIS_T = 2;
  localparam int MB_RST   = 0;

  localparam logic [7:0] MCTL_HELD = 8'h01;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_CLR_PS  = 3'd1,
    CMD_SET_SVC = 3'd2,
    CMD_CLR_SVC = 3'd3,
    CMD_SET_PND = 3'd4,
    CMD_CLR_PND = 3'd5,
    CMD_SET_EN  = 3'd6,
    CMD_CLR_EN  = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    GRP_A = 2'd0,
    GRP_B = 2'd1,
    GRP_T = 2'd2
  } grp_e;

  // priority index -> vector group: 1 is port A, 3 is port B, others timers
  function automatic grp_e grp_of(input int idx);
    if (idx == 1) return GRP_A;
    if (idx == 3) return GRP_B;
    return GRP_T;
  endfunction

  function automatic logic [7:0] pack_status(input logic ius, input logic ie,
                                             input logic ip, input logic err);
    return {ius, ie, ip, err, 4'b0000};
  endfunction

  function automatic logic [7:0] splice_vec(input logic [7:0] v,
                                            input logic [CODE_W-1:0] code,
                                            input logic ins);
    return ins ? {v[7:4], code, v[0]} : v;
  endfunction

endpackage

// File: rtl/icu_src_cell.sv
module icu_src_cell
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_clr,
  input  logic              cmd_we,
  input  cmd_e              cmd,
  input  logic              evt,
  input  logic [CODE_W-1:0] cond,
  input  logic              ack_set,
  output logic              ip,
  output logic              ie,
  output logic              ius,
  output logic              err,
  output logic [CODE_W-1:0] code
);

  // decoded command events, named for observation
  logic pnd_set_cmd, pnd_clr_cmd, svc_set_cmd, svc_clr_cmd, en_set_cmd, en_clr_cmd;
  logic overrun;

  always_comb begin
    pnd_set_cmd = cmd_we && (cmd == CMD_SET_PND);
    pnd_clr_cmd = cmd_we && ((cmd == CMD_CLR_PND) || (cmd == CMD_CLR_PS));
    svc_set_cmd = cmd_we && (cmd == CMD_SET_SVC);
    svc_clr_cmd = cmd_we && ((cmd == CMD_CLR_SVC) || (cmd == CMD_CLR_PS));
    en_set_cmd  = cmd_we && (cmd == CMD_SET_EN);
    en_clr_cmd  = cmd_we && (cmd == CMD_CLR_EN);
    overrun     = evt && ip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip   <= 1'b0;
      ie   <= 1'b0;
      ius  <= 1'b0;
      err  <= 1'b0;
      code <= '0;
    end else if (hold_clr) begin
      ip   <= 1'b0;
      ie   <= 1'b0;
      ius  <= 1'b0;
      err  <= 1'b0;
      code <= '0;
    end else begin
      // hardware event outranks a command that clears pending
      if (evt)              ip <= 1'b1;
      else if (pnd_clr_cmd) ip <= 1'b0;
      else if (pnd_set_cmd) ip <= 1'b1;

      if (overrun)          err <= 1'b1;
      else if (pnd_clr_cmd) err <= 1'b0;

      // acknowledge outranks a command that clears service
      if (ack_set)          ius <= 1'b1;
      else if (svc_clr_cmd) ius <= 1'b0;
      else if (svc_set_cmd) ius <= 1'b1;

      if (en_set_cmd)       ie <= 1'b1;
      else if (en_clr_cmd)  ie <= 1'b0;

      if (evt)              code <= cond;
    end
  end

endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
  parameter int N = 5
) (
  input  logic [N-1:0] cand,
  input  logic [N-1:0] ius,
  output logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);

  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] v);
    return v & (~v + {{(N-1){1'b0}}, 1'b1});
  endfunction

  logic [N-1:0] blocked;

  always_comb begin
    blocked[0] = ius[0];
    for (int i = 1; i < N; i++) blocked[i] = blocked[i-1] | ius[i];
  end

  assign req   = cand & ~blocked;
  assign grant = lowest_one(req);
  assign any   = |req;

endmodule

// File: rtl/icu_vec_unit.sv
module icu_vec_unit
  import icu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  addr_t             addr,
  input  logic [7:0]        wdata,
  input  logic              take,
  input  grp_e              win_grp,
  input  logic [CODE_W-1:0] win_code,
  input  logic [2:0]        ins_abt,
  input  logic              nv,
  output logic [7:0]        vec_a,
  output logic [7:0]        vec_b,
  output logic [7:0]        vec_t,
  output logic [7:0]        cur_vec,
  output logic              vec_drive
);

  logic [7:0] sel_vec;
  logic       sel_ins;

  always_comb begin
    case (win_grp)
      GRP_A:   begin sel_vec = vec_a; sel_ins = ins_abt[2]; end
      GRP_B:   begin sel_vec = vec_b; sel_ins = ins_abt[1]; end
      default: begin sel_vec = vec_t; sel_ins = ins_abt[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_a     <= '0;
      vec_b     <= '0;
      vec_t     <= '0;
      cur_vec   <= '0;
      vec_drive <= 1'b0;
    end else begin
      if (wr_en && addr == A_VEC_A) vec_a <= wdata;
      if (wr_en && addr == A_VEC_B) vec_b <= wdata;
      if (wr_en && addr == A_VEC_T) vec_t <= wdata;
      if (take) cur_vec <= splice_vec(sel_vec, win_code, sel_ins);
      vec_drive <= take && !nv;
    end
  end

endmodule

// File: rtl/icu_ctrl.sv
module icu_ctrl
  import icu_pkg::*;
#(
  parameter int N_SRC = NSRC_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  input  logic [N_SRC-1:0]        evt,
  input  logic [N_SRC*CODE_W-1:0] evt_cond,
  input  logic                    ack,
  output logic                    irq,
  output logic                    chain_out,
  output logic [7:0]              vec_out,
  output logic                    vec_drive
);

  logic [7:0] mctl;
  logic       mctl_we;
  logic       hold_clr;

  logic [N_SRC-1:0] ip, ie, ius, err;
  logic [N_SRC-1:0] cand, req, grant, ack_set, src_we;
  logic [CODE_W-1:0] code_q [N_SRC];
  logic             any_req, ack_take;

  grp_e              win_grp;
  logic [CODE_W-1:0] win_code;
  logic [7:0]        vec_a, vec_b, vec_t, cur_vec;

  assign mctl_we  = wr_en && (addr == A_MCTL);
  assign hold_clr = mctl[MB_RST] || (mctl_we && wdata[MB_RST]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mctl <= MCTL_HELD;
    else if (mctl_we) mctl <= wdata[MB_RST] ? MCTL_HELD : wdata;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      assign src_we[gi] = wr_en && (addr == A_SRC0 + addr_t'(gi));
      icu_src_cell u_cell (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (hold_clr),
        .cmd_we   (src_we[gi]),
        .cmd      (cmd_e'(wdata[7:5])),
        .evt      (evt[gi]),
        .cond     (evt_cond[gi*CODE_W +: CODE_W]),
        .ack_set  (ack_set[gi]),
        .ip       (ip[gi]),
        .ie       (ie[gi]),
        .ius      (ius[gi]),
        .err      (err[gi]),
        .code     (code_q[gi])
      );
    end
  endgenerate

  assign cand = ip & ie & {N_SRC{mctl[MB_MIE]}};

  icu_prio #(.N(N_SRC)) u_prio (
    .cand  (cand),
    .ius   (ius),
    .req   (req),
    .grant (grant),
    .any   (any_req)
  );

  assign ack_take = ack && any_req;
  assign ack_set  = grant & {N_SRC{ack_take}};

  always_comb begin
    win_grp  = GRP_T;
    win_code = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (grant[i]) begin
        win_grp  = grp_of(i);
        win_code = code_q[i];
      end
    end
  end

  icu_vec_unit u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .take      (ack_take),
    .win_grp   (win_grp),
    .win_code  (win_code),
    .ins_abt   ({mctl[MB_VIS_A], mctl[MB_VIS_B], mctl[MB_VIS_T]}),
    .nv        (mctl[MB_NV]),
    .vec_a     (vec_a),
    .vec_b     (vec_b),
    .vec_t     (vec_t),
    .cur_vec   (cur_vec),
    .vec_drive (vec_drive)
  );

  assign irq       = any_req;
  assign chain_out = ~(|ius) & ~mctl[MB_DLC];
  assign vec_out   = cur_vec;

  always_comb begin
    rdata = 8'h00;
    case (addr)
      A_MCTL:  rdata = mctl;
      A_VEC_A: rdata = vec_a;
      A_VEC_B: rdata = vec_b;
      A_VEC_T: rdata = vec_t;
      A_CUR:   rdata = cur_vec;
      default: begin
        for (int i = 0; i < N_SRC; i++)
          if (addr == A_SRC0 + addr_t'(i))
            rdata = pack_status(ius[i], ie[i], ip[i], err[i]);
      end
    endcase
  end

endmodule

// File: rtl/icu_ctrl_chk.sv
module icu_ctrl_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic [7:0]   mctl,
  input logic [N-1:0] ip,
  input logic [N-1:0] ie,
  input logic [N-1:0] ius,
  input logic [N-1:0] err,
  input logic [N-1:0] evt,
  input logic [N-1:0] grant,
  input logic         ack,
  input logic         irq,
  input logic         chain_out,
  input logic         vec_drive
);

  assert_irq_needs_mie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mctl[7]);

  assert_chain_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ius) || mctl[6]) |-> !chain_out);

  assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_ack_marks_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (mctl[0] || ((ius & $past(grant)) == $past(grant))));

  assert_drive_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> (vec_drive == !$past(mctl[5])));

  assert_no_drive_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq) |=> !vec_drive);

  assert_hold_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mctl[0] |-> ((ip | ie | ius | err) == '0));

  assert_error_needs_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((err & ~$past(err) & ~$past(evt)) == '0));

endmodule

bind icu_ctrl icu_ctrl_chk #(.N(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mctl      (mctl),
  .ip        (ip),
  .ie        (ie),
  .ius       (ius),
  .err       (err),
  .evt       (evt),
  .grant     (grant),
  .ack       (ack),
  .irq       (irq),
  .chain_out (chain_out),
  .vec_drive (vec_drive)
);

// File: tb/icu_ctrl_tb.sv
module icu_ctrl_tb;

  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = 4'd0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic [NS-1:0] evt = '0;
  logic [NS*3-1:0] evt_cond = '0;
  logic          ack = 1'b0;
  logic          irq, chain_out, vec_drive;
  logic [7:0]    vec_out;

  int total = 0;
  int bad = 0;
  logic [7:0] d;
  logic [7:0] expv;
  logic e_ip, e_ie, e_ius;
  int w, w2;
  logic blk;
  logic [NS-1:0] s2;
  logic [NS*3-1:0] cond_all;

  always #2 clk = ~clk;

  icu_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .evt_cond(evt_cond), .ack(ack), .irq(irq),
    .chain_out(chain_out), .vec_out(vec_out), .vec_drive(vec_drive)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk);
    addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic cmd(input int src, input int c);
    wr(4'(8 + src), {3'(c), 5'b0});
  endtask

  task automatic pulse_evt(input logic [NS-1:0] m, input logic [NS*3-1:0] c);
    @(negedge clk);
    evt = m; evt_cond = c;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) cond_all[i*3 +: 3] = 3'(i + 1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd0, d); chk("R1 master", d, 8'h01);
    for (int i = 0; i < NS; i++) begin
      rd(4'(8 + i), d); chk("R1 status", d, 8'h00);
    end
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 chain", {7'b0, chain_out}, 8'h01);
    chk("R1 drive", {7'b0, vec_drive}, 8'h00);

    // R3 / R5: every command from every flag state on every source
    for (int src = 0; src < NS; src++)
      for (int st = 0; st < 8; st++)
        for (int c = 0; c < 8; c++) begin
          wr(4'd0, 8'h01); wr(4'd0, 8'h80);
          if (st[0]) cmd(src, 4);
          if (st[1]) cmd(src, 6);
          if (st[2]) cmd(src, 2);
          cmd(src, c);
          e_ip = st[0]; e_ie = st[1]; e_ius = st[2];
          case (c)
            1: begin e_ip = 1'b0; e_ius = 1'b0; end
            2: e_ius = 1'b1;
            3: e_ius = 1'b0;
            4: e_ip = 1'b1;
            5: e_ip = 1'b0;
            6: e_ie = 1'b1;
            7: e_ie = 1'b0;
            default: ;
          endcase
          rd(4'(8 + src), d);
          chk("R3 command", d, {e_ius, e_ie, e_ip, 5'b0});
          chk("R5 single", {7'b0, irq}, {7'b0, e_ip & e_ie & ~e_ius});
        end

    // R5 master enable off blocks request
    wr(4'd0, 8'h01); wr(4'd0, 8'h00);
    cmd(2, 6); cmd(2, 4);
    chk("R5 mie off", {7'b0, irq}, 8'h00);

    // R4 error handling
    wr(4'd0, 8'h01); wr(4'd0, 8'h00);
    pulse_evt(5'b00100, cond_all);
    rd(4'd10, d); chk("R4 first evt", d, 8'h20);
    pulse_evt(5'b00100, cond_all);
    rd(4'd10, d); chk("R4 overrun", d, 8'h30);
    cmd(2, 3);
    rd(4'd10, d); chk("R4 kept", d, 8'h30);
    cmd(2, 5);
    rd(4'd10, d); chk("R4 clr pnd", d, 8'h00);
    pulse_evt(5'b00100, cond_all); pulse_evt(5'b00100, cond_all);
    cmd(2, 1);
    rd(4'd10, d); chk("R4 clr both", d, 8'h00);

    // R2 reset bit hold
    cmd(0, 6); pulse_evt(5'b00001, cond_all); cmd(0, 2);
    wr(4'd0, 8'h81);
    rd(4'd0, d); chk("R2 stored", d, 8'h01);
    rd(4'd8, d); chk("R2 cleared", d, 8'h00);
    pulse_evt(5'b00001, cond_all); cmd(0, 6);
    rd(4'd8, d); chk("R2 held", d, 8'h00);
    wr(4'd0, 8'h80);
    rd(4'd0, d); chk("R2 release", d, 8'h80);
    rd(4'd8, d); chk("R2 after", d, 8'h00);

    // vectors
    wr(4'd1, 8'h40); wr(4'd2, 8'h80); wr(4'd3, 8'hC0);

    // R6 / R7 / R8 / R5: all pending x service patterns
    for (int p = 0; p < 32; p++)
      for (int s = 0; s < 32; s++) begin
        wr(4'd0, 8'h01); wr(4'd0, 8'h9C);
        for (int i = 0; i < NS; i++) begin
          cmd(i, 6);
          if (s[i]) cmd(i, 2);
        end
        if (p != 0) pulse_evt(5'(p), cond_all);
        w = -1; blk = 1'b0;
        for (int i = 0; i < NS; i++) begin
          blk = blk | s[i];
          if (p[i] && !blk && w < 0) w = i;
        end
        chk("R5 prio irq", {7'b0, irq}, {7'b0, w >= 0});
        do_ack();
        if (w >= 0) begin
          expv = (w == 1) ? 8'h40 : (w == 3) ? 8'h80 : 8'hC0;
          expv = expv | 8'(((w + 1) << 1));
          chk("R7 vector", vec_out, expv);
          chk("R8 drive", {7'b0, vec_drive}, 8'h01);
          s2 = 5'(s) | 5'(1 << w);
          w2 = -1; blk = 1'b0;
          for (int i = 0; i < NS; i++) begin
            blk = blk | s2[i];
            if (p[i] && !blk && w2 < 0) w2 = i;
          end
          chk("R6 post ack irq", {7'b0, irq}, {7'b0, w2 >= 0});
        end else begin
          chk("R6 idle ack", {7'b0, vec_drive}, 8'h00);
        end
      end

    // R7 no insertion; R8 no-vector
    wr(4'd3, 8'hCF);
    wr(4'd0, 8'h01); wr(4'd0, 8'hA0);
    cmd(4, 6); pulse_evt(5'b10000, cond_all);
    do_ack();
    chk("R8 nv drive", {7'b0, vec_drive}, 8'h00);
    chk("R7 plain vector", vec_out, 8'hCF);
    rd(4'd12, d); chk("R6 nv service", d, 8'hE0);
    chk("R9 service chain", {7'b0, chain_out}, 8'h00);
    cmd(4, 3);
    chk("R9 chain free", {7'b0, chain_out}, 8'h01);

    // R6 ack with nothing requesting
    wr(4'd0, 8'h01); wr(4'd0, 8'h80);
    do_ack();
    chk("R6 no req drive", {7'b0, vec_drive}, 8'h00);
    rd(4'd4, d); chk("R6 no req vec", d, 8'hCF);

    // R9 disable lower chain
    wr(4'd0, 8'hC0);
    chk("R9 dlc", {7'b0, chain_out}, 8'h00);
    wr(4'd0, 8'h80);
    chk("R9 dlc off", {7'b0, chain_out}, 8'h01);

    // R10 collisions
    @(negedge clk);
    addr = 4'd9; wdata = 8'hA0; wr_en = 1'b1; evt = 5'b00010; evt_cond = cond_all;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(4'd9, d); chk("R10 evt beats clr", d, 8'h20);
    cmd(1, 6);
    @(negedge clk);
    addr = 4'd9; wdata = 8'h60; wr_en = 1'b1; ack = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ack = 1'b0;
    rd(4'd9, d); chk("R10 ack beats clr", d, 8'hE0);

    // R11 read-only and unmapped
    rd(4'd4, d); expv = d;
    wr(4'd4, 8'h55);
    rd(4'd4, d); chk("R11 ro", d, expv);
    rd(4'd5, d); chk("R11 gap", d, 8'h00);
    rd(4'd13, d); chk("R11 high", d, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule